// File: doc/BRIEF.md
# Fractional PLL Frequency Calculator

This block works out the output frequency of a fractional-N synthesizer from a 32-bit control word and a 32-bit reference frequency in hertz. The control word holds four fields: a post-divider, a fractional denominator, an integer multiplier and a signed fractional numerator. The block decodes these fields, clamps the integer multiplier to a minimum of five and sign-extends the numerator. It scales the reference down by 2^10 and forms a wide numerator and a divisor. A restoring divider then produces one quotient bit per clock. The quotient, scaled back up by 2^10, appears on the frequency output together with a one-cycle done pulse.

A caller pulses `calc_start` with the word and the reference. The result is ready a fixed number of cycles later. The frequency output keeps the last result until the next accepted calculation finishes. A start pulse that arrives while a calculation is running is dropped.

Top module: `pll_freq_calc`

## Requirements
- R1: After synchronous reset, `freq_hz` is 0 and `calc_done` is low.
- R2: The denominator used is the control word's bits 25:16 plus one (range 1..1024).
- R3: The integer multiplier is bits 13:10. Any value below 5 is replaced by 5, so fields 0 to 4 give the same result as field 5.
- R4: The numerator is bits 9:0, read as a 10-bit two's-complement value (0x3FF is -1, 0x200 is -512).
- R5: The post-divider is bits 29:26 plus one (range 1..16). Bits 31:30 and 15:14 have no effect.
- R6: With S = mfi*mfd + mfn, the result is the low 32 bits of ((2*(ref>>10)*S) / (mfd*pd)) << 10. The division truncates toward zero.
- R7: When S is zero or negative, the result is 0.
- R8: `calc_done` is high for exactly one cycle. It rises after the 49th rising edge counted from the edge that samples `calc_start`, and `freq_hz` carries the new value in that same cycle.
- R9: A `calc_start` that arrives while a calculation is running is ignored. It produces no extra `calc_done`, and the running result is unchanged.
- R10: `freq_hz` holds the previous result while a new calculation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| calc_start | input | 1 | Start strobe; sampled with the two inputs below |
| pll_word | input | 32 | PLL control word |
| ref_hz | input | 32 | Reference frequency in hertz |
| freq_hz | output | 32 | Computed output frequency in hertz |
| calc_done | output | 1 | One-cycle pulse when `freq_hz` is updated |

## Verification
Each accepted start produces exactly one result. That result is due 48 edges after the edge that samples the start, which is 49 edges counting the sampling edge. The driver records the cycle of the sampling edge and pushes it into the scoreboard with the expected frequency. The monitor samples on the falling edge. When it sees `calc_done`, it compares the frequency and checks that the elapsed cycle count is exactly 48. On the next falling edge it checks that the pulse has dropped. Partway through a calculation, the driver samples `freq_hz` against the previous expected value, and it may inject a second start that the scoreboard must never see answered.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    localparam int CW      = 32;            // word and frequency width
    localparam int SCALE   = 10;            // reference pre-scale shift
    localparam int PROD_W  = 48;            // dividend width
    localparam int DIV_W   = 15;            // divisor width (1024*16 fits)
    localparam int SUM_W   = 16;            // signed mfi*mfd+mfn width
    localparam int MFI_MIN = 5;

    // field positions in the control word
    localparam int PD_LSB  = 26;
    localparam int PD_W    = 4;
    localparam int DEN_LSB = 16;
    localparam int DEN_W   = 10;
    localparam int MFI_LSB = 10;
    localparam int MFI_W   = 4;
    localparam int MFN_LSB = 0;
    localparam int MFN_W   = 10;

    typedef struct packed {
        logic [PD_W-1:0]         pd_f;
        logic [DEN_W-1:0]        den_f;
        logic [MFI_W-1:0]        mfi_f;
        logic signed [MFN_W-1:0] mfn_f;
    } pll_fields_t;

    typedef struct packed {
        logic [PROD_W-1:0] dividend;
        logic [DIV_W-1:0]  divisor;
    } div_job_t;

    function automatic pll_fields_t split_word(input logic [CW-1:0] w);
        pll_fields_t f;
        f.pd_f  = w[PD_LSB  +: PD_W];
        f.den_f = w[DEN_LSB +: DEN_W];
        f.mfi_f = w[MFI_LSB +: MFI_W];
        f.mfn_f = w[MFN_LSB +: MFN_W];
        return f;
    endfunction

endpackage

// File: rtl/pll_word_decode.sv
module pll_word_decode
    import pll_calc_pkg::*;
(
    input  logic [CW-1:0] word_i,
    input  logic [CW-1:0] ref_i,
    output div_job_t      job_o
);
    pll_fields_t             fld;
    logic [MFI_W-1:0]        mfi_eff;
    logic [DEN_W:0]          mfd;
    logic [PD_W:0]           pd;
    logic signed [SUM_W-1:0] sum;
    logic [CW-SCALE-1:0]     ref_s;

    always_comb begin
        fld     = split_word(word_i);
        mfi_eff = (fld.mfi_f < MFI_W'(MFI_MIN)) ? MFI_W'(MFI_MIN) : fld.mfi_f;
        mfd     = {1'b0, fld.den_f} + 1'b1;
        pd      = {1'b0, fld.pd_f} + 1'b1;
        ref_s   = ref_i[CW-1:SCALE];
        sum     = $signed(SUM_W'(mfi_eff) * SUM_W'(mfd)) + SUM_W'(fld.mfn_f);
        job_o.divisor = DIV_W'(mfd) * DIV_W'(pd);
        if (sum > 0)
            job_o.dividend = PROD_W'({ref_s, 1'b0}) * PROD_W'(sum[SUM_W-2:0]);
        else
            job_o.dividend = '0;
    end

    // R2 R5: divisor never zero
    always_comb begin
        divisor_nonzero_chk: assert (job_o.divisor != '0);
    end
endmodule

// File: rtl/pll_seq_divider.sv
module pll_seq_divider
    import pll_calc_pkg::*;
#(
    parameter int N_W = PROD_W,
    parameter int D_W = DIV_W,
    parameter int Q_W = CW - SCALE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [N_W-1:0] dividend_i,
    input  logic [D_W-1:0] divisor_i,
    output logic           busy_o,
    output logic           valid_o,
    output logic [Q_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [N_W-1:0]   dvd_q;
    logic [D_W-1:0]   dvs_q;
    logic [D_W-1:0]   rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic [D_W:0]     shifted;
    logic [D_W:0]     diff;
    logic             take;
    logic [N_W-1:0]   dvd_nxt;

    always_comb begin
        shifted = {rem_q, dvd_q[N_W-1]};
        take    = shifted >= {1'b0, dvs_q};
        diff    = shifted - {1'b0, dvs_q};
        dvd_nxt = {dvd_q[N_W-2:0], take};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q   <= '0;
            dvs_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            busy_o  <= 1'b0;
            valid_o <= 1'b0;
            quot_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            if (busy_o) begin
                rem_q <= take ? diff[D_W-1:0] : shifted[D_W-1:0];
                dvd_q <= dvd_nxt;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_o  <= 1'b0;
                    valid_o <= 1'b1;
                    quot_o  <= dvd_nxt[Q_W-1:0];
                end
            end else if (load_i) begin
                dvd_q  <= dividend_i;
                dvs_q  <= divisor_i;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(N_W);
                busy_o <= 1'b1;
            end
        end
    end

    // R6: partial remainder stays below the divisor
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> rem_q < dvs_q);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R8
    valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !busy_o && $past(busy_o));
    // R10
    quot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && cnt_q != CNT_W'(1) |=> $stable(quot_o));
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pll_calc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          calc_start,
    input  logic [CW-1:0] pll_word,
    input  logic [CW-1:0] ref_hz,
    output logic [CW-1:0] freq_hz,
    output logic          calc_done
);
    div_job_t            job;
    logic                busy;
    logic                load;
    logic [CW-SCALE-1:0] quot;

    pll_word_decode u_decode (
        .word_i (pll_word),
        .ref_i  (ref_hz),
        .job_o  (job)
    );

    assign load = calc_start && !busy;

    pll_seq_divider #(
        .N_W (PROD_W),
        .D_W (DIV_W),
        .Q_W (CW - SCALE)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .dividend_i (job.dividend),
        .divisor_i  (job.divisor),
        .busy_o     (busy),
        .valid_o    (calc_done),
        .quot_o     (quot)
    );

    assign freq_hz = {quot, {SCALE{1'b0}}};

    // R9: a start while busy must not restart the sequence
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy && calc_start |=> busy || calc_done);
    // R10
    freq_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !calc_done |-> $stable(freq_hz) || $past(rst));
endmodule

// File: tb/pll_freq_calc_test.sv
module pll_freq_calc_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 48;

    typedef struct {
        logic [31:0] freq;
        int          cyc;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        calc_start = 0;
    logic [31:0] pll_word = '0;
    logic [31:0] ref_hz = '0;
    logic [31:0] freq_hz;
    logic        calc_done;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    exp_t sb[$];
    logic [31:0] last_exp = '0;
    logic        done_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_freq_calc uut (
        .clk(clk), .rst(rst), .calc_start(calc_start),
        .pll_word(pll_word), .ref_hz(ref_hz),
        .freq_hz(freq_hz), .calc_done(calc_done)
    );

    function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] r);
        longint pd, mfd, mfi, mfn, s, q;
        pd  = longint'(w[29:26]) + 1;
        mfd = longint'(w[25:16]) + 1;
        mfi = longint'(w[13:10]);
        if (mfi < 5) mfi = 5;
        mfn = longint'(w[9:0]);
        if (mfn >= 512) mfn = mfn - 1024;
        s = mfi * mfd + mfn;
        if (s <= 0) return 32'd0;
        q = (2 * longint'(r >> 10) * s) / (mfd * pd);
        return 32'(q << 10);
    endfunction

    function automatic logic [31:0] mkword(input int pdf, input int den, input int mfi, input int mfn);
        return (32'(pdf) << 26) | (32'(den) << 16) | (32'(mfi) << 10) | 32'(mfn & 10'h3FF);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
        end
    endtask

    // driver: issues a calculation and pushes the expectation
    task automatic run(input string tag, input logic [31:0] w, input logic [31:0] r,
                       input bit poke_busy);
        exp_t e;
        @(negedge clk);
        calc_start = 1; pll_word = w; ref_hz = r;
        @(posedge clk);
        e.freq = model(w, r); e.cyc = cyc + 1; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        calc_start = 0;
        repeat (10) @(negedge clk);
        if (poke_busy) begin
            // R9: second start with a different word while busy
            calc_start = 1; pll_word = mkword(0, 0, 15, 0); ref_hz = 32'hFFFF_FFFF;
            @(negedge clk);
            calc_start = 0;
        end
        repeat (10) @(negedge clk);
        check("R10 hold during calc", freq_hz, last_exp);
        while (sb.size() != 0) @(negedge clk);
        last_exp = e.freq;
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares results and timing
    always @(negedge clk) begin
        if (!rst) begin
            if (done_prev) check("R8 done one cycle", {31'd0, calc_done}, 32'd0);
            if (calc_done) begin
                if (sb.size() == 0) begin
                    check("R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, freq_hz, e.freq);
                    check("R8 latency", 32'(cyc - e.cyc), 32'(LAT));
                end
            end
            done_prev = calc_done;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset freq", freq_hz, 32'd0);
        check("R1 reset done", {31'd0, calc_done}, 32'd0);

        run("R6 basic", mkword(0, 0, 6, 0), 32'd26_000_000, 0);
        run("R2 denominator", mkword(0, 4, 12, 1), 32'd26_000_000, 0);
        // R3: clamped field gives same result as 5
        run("R3 mfi=2 clamps", mkword(1, 3, 2, 7), 32'd24_000_000, 0);
        w = mkword(1, 3, 2, 7);
        check("R3 model equality", model(w, 32'd24_000_000),
              model(mkword(1, 3, 5, 7), 32'd24_000_000));
        run("R3 mfi=0 clamps", mkword(1, 3, 0, 7), 32'd24_000_000, 0);
        run("R4 mfn=-1", mkword(0, 4, 12, -1), 32'd26_000_000, 0);
        run("R4 mfn=-512", mkword(2, 1023, 9, -512), 32'd33_554_432, 0);
        run("R5 pd=16", mkword(15, 1023, 15, 511), 32'd26_000_000, 0);
        // R5: unused bits set
        run("R5 spare bits", mkword(3, 10, 7, 20) | 32'hC000_C000, 32'd19_200_000, 0);
        check("R5 spare model", model(mkword(3, 10, 7, 20), 32'd19_200_000),
              model(mkword(3, 10, 7, 20) | 32'hC000_C000, 32'd19_200_000));
        run("R7 negative sum", mkword(0, 0, 0, -100), 32'd26_000_000, 0);
        run("R7 zero sum", mkword(0, 1, 5, -10), 32'd26_000_000, 0);
        run("R6 wrap", mkword(0, 1023, 15, 511), 32'hFFFF_FFFF, 0);
        run("R9 busy start", mkword(1, 2, 8, 100), 32'd12_000_000, 1);
        for (int i = 0; i < 6; i++) begin
            run("R6 sweep", mkword(i * 3 % 16, (i * 171) % 1024, (i * 5) % 16, (i * 97) - 300),
                32'd1_000_000 + 32'(i) * 32'd7_777_777, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule